// File: doc/BRIEF.md
# Decimating FIR Filter with Folded Taps

This block is a time-shared FIR filter that reduces the sample rate. Each accepted input sample enters a delay line. When the sample is one the decimation count selects, a single multiply-accumulate unit walks through the taps, one tap per clock, and produces one filtered output. Coefficients come from an external 64-entry RAM through a read address and a combinational read-data port. The base address of that RAM is programmable, so several coefficient sets can be stored at once and the active set can be switched while the filter runs. A new base address takes effect only at the start of the next output computation.

In symmetric mode, each stored coefficient serves two mirrored taps. The two samples are pre-added before the multiply, so 64 stored coefficients cover up to 128 taps. The accumulated sum is scaled down in 6 dB steps and saturated to the output width. A bypass routes every input straight to the output. The integrator must space input samples so that each computation finishes before the next sample arrives.

Top module: `decim_fir`

## Requirements
- R1: While reset is asserted and just after it, `out_valid` is 0 and `out_data` is 0. The delay line and the decimation counter clear to zero.
- R2: In plain mode, an output equals sum over j of `C[j]*x[j]`. `x[0]` is the sample just accepted, `x[j]` is the sample accepted j samples earlier (zero before reset), and `C[j]` is RAM word `(cfg_coef_base + j) mod 64`. Coefficients are signed with 19 fraction bits, so the sum is shifted right arithmetically by 19 before scaling.
- R3: In plain mode the tap count is `cfg_taps_m1 + 1`, limited to 64 taps when `cfg_taps_m1` exceeds 63.
- R4: With `cfg_sym` = 1 and N = `cfg_taps_m1 + 1`, the output is the sum, for j from 0 to ceil(N/2)-1, of `C[j]*(x[j] + x[N-1-j])`. For odd N the centre tap (j = N-1-j) adds `x[j]` only once.
- R5: `cfg_scale` selects an extra arithmetic right shift of 3, 2, 1 or 0 bits for codes 00, 01, 10 and 11. The shift rounds toward minus infinity.
- R6: A scaled result outside the signed 20-bit range saturates to 524287 or -524288.
- R7: A decimation counter advances on each accepted sample and wraps to 0 after reaching `cfg_dec_m1` (rate = value + 1). A sample produces an output only if the counter equals `cfg_phase` when that sample arrives.
- R8: `out_valid` is a one-cycle pulse. It rises at the (M+1)-th rising edge after the edge that accepts the sample, where M is the number of multiply cycles (taps in plain mode, ceil(N/2) in symmetric mode).
- R9: With `cfg_bypass` = 1, each input appears unchanged on `out_data` with `out_valid` high at the clock edge that accepts it. No decimation or scaling is applied.
- R10: The coefficient base, tap count, symmetry and scale are captured when a computation starts. During the computation `coef_addr` steps through base, base+1, and so on, modulo 64. A change of `cfg_coef_base` mid-computation affects only the next output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 20 | Signed input sample |
| cfg_taps_m1 | input | 7 | Tap count minus one |
| cfg_dec_m1 | input | 4 | Decimation rate minus one |
| cfg_phase | input | 4 | Decimation count value that yields an output |
| cfg_sym | input | 1 | Symmetric (folded) coefficient mode |
| cfg_scale | input | 2 | Output attenuation code |
| cfg_coef_base | input | 6 | Coefficient RAM base address |
| cfg_bypass | input | 1 | Pass input to output unchanged |
| coef_addr | output | 6 | Coefficient RAM read address |
| coef_data | input | 20 | Signed coefficient read data (combinational) |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 20 | Signed filtered output |

## Verification
Two functions can land in the same cycle: a change of the coefficient base and an output computation that is in progress. The bench provokes this by rewriting `cfg_coef_base` three cycles after a sample is accepted, while the multiply loop is still reading coefficients. It judges the result by checking that this output matches a model built on the old base, and that the following output matches the new one. A second overlap is the final multiply cycle coinciding with the folded centre tap of an odd-length symmetric filter. Odd tap counts are compared against the model to confirm that the centre sample is counted once.

// File: rtl/dfir_pkg.sv
package dfir_pkg;
    localparam int DATA_W_DEF    = 20;
    localparam int COEF_W_DEF    = 20;
    localparam int RAM_DEPTH_DEF = 64;
    localparam int DEC_W_DEF     = 4;
    localparam int ACC_W_DEF     = 48;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/dfir_line.sv
module dfir_line #(
    parameter int DATA_W = 20,
    parameter int DEPTH  = 128,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     shift,
    input  logic signed [DATA_W-1:0] din,
    input  logic [IDX_W-1:0]         rd_a,
    input  logic [IDX_W-1:0]         rd_b,
    output logic signed [DATA_W-1:0] dout_a,
    output logic signed [DATA_W-1:0] dout_b
);
    logic signed [DATA_W-1:0] line_d [DEPTH];
    logic signed [DATA_W-1:0] line_q [DEPTH];

    // newest sample enters slot 0; every other slot takes its neighbour
    assign line_d[0] = shift ? din : line_q[0];
    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
        assign line_d[g] = shift ? line_q[g-1] : line_q[g];
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            line_q[i] <= rst_n ? line_d[i] : '0;
        end
    end

    assign dout_a = line_q[rd_a];
    assign dout_b = line_q[rd_b];
endmodule

// File: rtl/dfir_mac.sv
module dfir_mac #(
    parameter int DATA_W = 20,
    parameter int COEF_W = 20,
    parameter int ACC_W  = 48,
    localparam int SUM_W  = DATA_W + 1,
    localparam int PROD_W = SUM_W + COEF_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     en,
    input  logic                     use_b,
    input  logic signed [DATA_W-1:0] a,
    input  logic signed [DATA_W-1:0] b,
    input  logic signed [COEF_W-1:0] coef,
    output logic signed [ACC_W-1:0]  acc
);
    logic signed [SUM_W-1:0]  pre_sum;
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  acc_d, acc_q;

    always_comb begin
        pre_sum = {a[DATA_W-1], a};
        if (use_b) begin
            pre_sum = pre_sum + {b[DATA_W-1], b};
        end
        prod = pre_sum * coef;
        acc_d = acc_q;
        if (clr) begin
            acc_d = '0;
        end else if (en) begin
            acc_d = acc_q + ACC_W'(prod);
        end
    end

    always_ff @(posedge clk) begin
        acc_q <= rst_n ? acc_d : '0;
    end

    assign acc = acc_q;
endmodule

// File: rtl/dfir_seq.sv
module dfir_seq
    import dfir_pkg::*;
#(
    parameter int TAP_W  = 7,
    parameter int ADDR_W = 6,
    parameter int DEC_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              bypass,
    input  logic [TAP_W-1:0]  taps_m1,
    input  logic [DEC_W-1:0]  dec_m1,
    input  logic [DEC_W-1:0]  phase,
    input  logic              sym,
    input  logic [1:0]        scale,
    input  logic [ADDR_W-1:0] base,
    output logic              start,
    output logic              run,
    output logic              fin,
    output logic [ADDR_W-1:0] addr,
    output logic [TAP_W-1:0]  idx_a,
    output logic [TAP_W-1:0]  idx_b,
    output logic              use_b,
    output logic [1:0]        scale_l
);
    localparam logic [TAP_W-1:0] PLAIN_MAX = TAP_W'((1 << ADDR_W) - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [DEC_W-1:0]  dec_cnt;
        logic [ADDR_W-1:0] j;
        logic [ADDR_W-1:0] m_m1;
        logic [ADDR_W-1:0] base;
        logic [TAP_W-1:0]  n_m1;
        logic              sym;
        logic [1:0]        scale;
    } seq_t;

    seq_t s_d, s_q;
    logic accept, fire;

    always_comb begin
        s_d    = s_q;
        start  = 1'b0;
        accept = in_valid && !bypass;
        fire   = accept && (s_q.dec_cnt == phase);
        if (accept) begin
            s_d.dec_cnt = (s_q.dec_cnt >= dec_m1) ? '0 : s_q.dec_cnt + 1'b1;
        end
        case (s_q.st)
            ST_IDLE: begin
                if (fire) begin
                    start      = 1'b1;
                    s_d.st     = ST_RUN;
                    s_d.j      = '0;
                    s_d.n_m1   = taps_m1;
                    s_d.sym    = sym;
                    s_d.scale  = scale;
                    s_d.base   = base;
                    s_d.m_m1   = sym ? ADDR_W'(taps_m1 >> 1)
                                     : ADDR_W'((taps_m1 > PLAIN_MAX) ? PLAIN_MAX : taps_m1);
                end
            end
            ST_RUN: begin
                s_d.j = s_q.j + 1'b1;
                if (s_q.j == s_q.m_m1) begin
                    s_d.st = ST_FIN;
                end
            end
            ST_FIN:  s_d.st = ST_IDLE;
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign run     = (s_q.st == ST_RUN);
    assign fin     = (s_q.st == ST_FIN);
    assign addr    = s_q.base + s_q.j;
    assign idx_a   = TAP_W'(s_q.j);
    assign idx_b   = s_q.n_m1 - idx_a;
    assign use_b   = s_q.sym && (idx_b != idx_a);
    assign scale_l = s_q.scale;
endmodule

// File: rtl/decim_fir.sv
module decim_fir
    import dfir_pkg::*;
#(
    parameter int DATA_W    = DATA_W_DEF,
    parameter int COEF_W    = COEF_W_DEF,
    parameter int RAM_DEPTH = RAM_DEPTH_DEF,
    parameter int DEC_W     = DEC_W_DEF,
    parameter int ACC_W     = ACC_W_DEF,
    localparam int ADDR_W     = $clog2(RAM_DEPTH),
    localparam int LINE_DEPTH = 2 * RAM_DEPTH,
    localparam int TAP_W      = $clog2(LINE_DEPTH),
    localparam int FRAC       = COEF_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [TAP_W-1:0]  cfg_taps_m1,
    input  logic [DEC_W-1:0]  cfg_dec_m1,
    input  logic [DEC_W-1:0]  cfg_phase,
    input  logic              cfg_sym,
    input  logic [1:0]        cfg_scale,
    input  logic [ADDR_W-1:0] cfg_coef_base,
    input  logic              cfg_bypass,
    output logic [ADDR_W-1:0] coef_addr,
    input  logic [COEF_W-1:0] coef_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    localparam logic signed [ACC_W-1:0] SAT_HI =
        $signed({{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}});
    localparam logic signed [ACC_W-1:0] SAT_LO =
        $signed({{(ACC_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}});

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } out_t;

    logic                     seq_start, seq_run, seq_fin, seq_use_b;
    logic [TAP_W-1:0]         idx_a, idx_b;
    logic [1:0]               scale_l;
    logic signed [DATA_W-1:0] tap_a, tap_b;
    logic signed [ACC_W-1:0]  mac_acc;
    logic signed [ACC_W-1:0]  shifted;
    logic [1:0]               extra_sh;
    out_t                     o_d, o_q;

    dfir_seq #(.TAP_W(TAP_W), .ADDR_W(ADDR_W), .DEC_W(DEC_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .bypass  (cfg_bypass),
        .taps_m1 (cfg_taps_m1),
        .dec_m1  (cfg_dec_m1),
        .phase   (cfg_phase),
        .sym     (cfg_sym),
        .scale   (cfg_scale),
        .base    (cfg_coef_base),
        .start   (seq_start),
        .run     (seq_run),
        .fin     (seq_fin),
        .addr    (coef_addr),
        .idx_a   (idx_a),
        .idx_b   (idx_b),
        .use_b   (seq_use_b),
        .scale_l (scale_l)
    );

    dfir_line #(.DATA_W(DATA_W), .DEPTH(LINE_DEPTH)) u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .shift (in_valid && !cfg_bypass),
        .din   ($signed(in_data)),
        .rd_a  (idx_a),
        .rd_b  (idx_b),
        .dout_a(tap_a),
        .dout_b(tap_b)
    );

    dfir_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_mac (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (seq_start),
        .en   (seq_run),
        .use_b(seq_use_b),
        .a    (tap_a),
        .b    (tap_b),
        .coef ($signed(coef_data)),
        .acc  (mac_acc)
    );

    always_comb begin
        extra_sh = 2'd3 - scale_l;
        shifted  = mac_acc >>> (FRAC + int'(extra_sh));
        o_d       = o_q;
        o_d.valid = 1'b0;
        if (cfg_bypass && in_valid) begin
            o_d.valid = 1'b1;
            o_d.data  = in_data;
        end else if (seq_fin) begin
            o_d.valid = 1'b1;
            if (shifted > SAT_HI) begin
                o_d.data = SAT_HI[DATA_W-1:0];
            end else if (shifted < SAT_LO) begin
                o_d.data = SAT_LO[DATA_W-1:0];
            end else begin
                o_d.data = shifted[DATA_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        o_q <= rst_n ? o_d : '0;
    end

    assign out_valid = o_q.valid;
    assign out_data  = o_q.data;
endmodule

// File: rtl/dfir_chk.sv
module dfir_chk #(
    parameter int DATA_W = 20,
    parameter int ADDR_W = 6,
    parameter int ACC_W  = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic              cfg_bypass,
    input logic [ADDR_W-1:0] cfg_coef_base,
    input logic [ADDR_W-1:0] coef_addr,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              run,
    input logic              fin,
    input logic [ACC_W-1:0]  acc
);
    // R10
    base_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> coef_addr == $past(cfg_coef_base));

    // R10
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> coef_addr == ADDR_W'($past(coef_addr) + 1'b1));

    // R2
    acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> acc == '0);

    // R8
    fin_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> out_valid);

    // R9
    bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bypass && in_valid) |=> (out_valid && out_data == $past(in_data)));
endmodule

bind decim_fir dfir_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .ACC_W(ACC_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_data      (in_data),
    .cfg_bypass   (cfg_bypass),
    .cfg_coef_base(cfg_coef_base),
    .coef_addr    (coef_addr),
    .out_valid    (out_valid),
    .out_data     (out_data),
    .run          (seq_run),
    .fin          (seq_fin),
    .acc          (mac_acc)
);

// File: tb/decim_fir_tb.sv
module decim_fir_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [19:0] in_data = '0;
    logic [6:0]  cfg_taps_m1 = '0;
    logic [3:0]  cfg_dec_m1 = '0;
    logic [3:0]  cfg_phase = '0;
    logic        cfg_sym = 1'b0;
    logic [1:0]  cfg_scale = 2'd3;
    logic [5:0]  cfg_coef_base = '0;
    logic        cfg_bypass = 1'b0;
    logic [5:0]  coef_addr;
    logic [19:0] coef_data;
    logic        out_valid;
    logic [19:0] out_data;

    logic signed [19:0] ram [64];
    longint hist [128];
    int     dec_cnt_m;
    int     exp_m;
    int     errors = 0;
    int     checks = 0;
    bit     done = 1'b0;

    always #4 clk = ~clk;
    assign coef_data = ram[coef_addr];

    decim_fir u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .cfg_taps_m1(cfg_taps_m1), .cfg_dec_m1(cfg_dec_m1), .cfg_phase(cfg_phase),
        .cfg_sym(cfg_sym), .cfg_scale(cfg_scale), .cfg_coef_base(cfg_coef_base),
        .cfg_bypass(cfg_bypass), .coef_addr(coef_addr), .coef_data(coef_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint model();
        int     n_m1 = int'(cfg_taps_m1);
        longint acc = 0;
        longint s;
        int     sh;
        if (cfg_sym) exp_m = n_m1 / 2 + 1;
        else         exp_m = (n_m1 > 63) ? 64 : n_m1 + 1;
        for (int j = 0; j < exp_m; j++) begin
            s = hist[j];
            if (cfg_sym && (n_m1 - j) != j) s += hist[n_m1 - j];
            acc += s * longint'(ram[(int'(cfg_coef_base) + j) % 64]);
        end
        sh = 3 - int'(cfg_scale);
        acc = acc >>> (19 + sh);
        if (acc > 524287) acc = 524287;
        if (acc < -524288) acc = -524288;
        return acc;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        for (int i = 0; i < 128; i++) hist[i] = 0;
        dec_cnt_m = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send_sample(input longint x, input string req,
                               input int chg_at, input int chg_base);
        longint e;
        bit     fire;
        int     got = 0;
        if (cfg_bypass) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = 20'(x);
            @(negedge clk);
            in_valid = 1'b0;
            check(out_valid == 1'b1, "R9 valid", longint'(out_valid), 1);
            check($signed(out_data) == x, "R9 data", longint'($signed(out_data)), x);
            @(negedge clk);
            check(out_valid == 1'b0, "R9 pulse", longint'(out_valid), 0);
            return;
        end
        for (int i = 127; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = x;
        fire = (dec_cnt_m == int'(cfg_phase));
        dec_cnt_m = (dec_cnt_m >= int'(cfg_dec_m1)) ? 0 : dec_cnt_m + 1;
        e = model();
        @(negedge clk);
        in_valid = 1'b1; in_data = 20'(x);
        @(negedge clk);
        in_valid = 1'b0;
        for (int c = 2; c <= 200; c++) begin
            @(negedge clk);
            if (c == chg_at) cfg_coef_base = 6'(chg_base);
            if (out_valid) begin got = c - 1; break; end
        end
        if (fire) begin
            check(got == exp_m + 1, "R8 latency", got, exp_m + 1);
            check($signed(out_data) == e, req, longint'($signed(out_data)), e);
            @(negedge clk);
            check(out_valid == 1'b0, "R8 pulse", longint'(out_valid), 0);
        end else begin
            check(got == 0, "R7 no output", got, 0);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(out_valid == 1'b0, "R1 valid", longint'(out_valid), 0);
        check(out_data == '0, "R1 data", longint'(out_data), 0);
        do_reset();
        check(out_valid == 1'b0 && out_data == '0, "R1 after", longint'(out_data), 0);
    endtask

    task automatic t_plain();
        cfg_sym = 0; cfg_taps_m1 = 7'd3; cfg_dec_m1 = 0; cfg_phase = 0;
        cfg_scale = 2'd3; cfg_coef_base = 0;
        ram[0] = 20'sd262144; ram[1] = -20'sd131072; ram[2] = 20'sd65536; ram[3] = 20'sd100000;
        do_reset();
        send_sample(400000, "R2 plain", 0, 0);
        send_sample(-250000, "R2 plain", 0, 0);
        send_sample(123457, "R2 plain", 0, 0);
        send_sample(-1, "R2 plain", 0, 0);
        send_sample(524287, "R2 plain", 0, 0);
    endtask

    task automatic t_clamp();
        for (int i = 0; i < 64; i++) ram[i] = 20'((i * 7919) % 40000 - 20000);
        cfg_sym = 0; cfg_taps_m1 = 7'd100; cfg_scale = 2'd3; cfg_coef_base = 0;
        do_reset();
        send_sample(300000, "R3 clamp", 0, 0);
        send_sample(-200000, "R3 clamp", 0, 0);
        cfg_taps_m1 = 7'd63;
        send_sample(77777, "R3 full", 0, 0);
    endtask

    task automatic t_sym();
        for (int i = 0; i < 64; i++) ram[i] = 20'((i * 3571) % 60000 - 30000);
        cfg_sym = 1; cfg_taps_m1 = 7'd4; cfg_scale = 2'd3; cfg_coef_base = 0;
        do_reset();
        for (int k = 0; k < 7; k++) send_sample(longint'(k * 61111 - 150000), "R4 odd", 0, 0);
        cfg_taps_m1 = 7'd15;
        for (int k = 0; k < 18; k++) send_sample(longint'((k * 40503) % 200000 - 90000), "R4 even", 0, 0);
        cfg_taps_m1 = 7'd127;
        for (int k = 0; k < 4; k++) send_sample(longint'(k * 99991 - 200000), "R4 max", 0, 0);
    endtask

    task automatic t_scale();
        cfg_sym = 0; cfg_taps_m1 = 7'd1; cfg_coef_base = 0;
        ram[0] = 20'sd524287; ram[1] = -20'sd3;
        do_reset();
        for (int s = 0; s < 4; s++) begin
            cfg_scale = 2'(s);
            send_sample(300001, "R5 scale", 0, 0);
            send_sample(-77777, "R5 scale", 0, 0);
        end
    endtask

    task automatic t_sat();
        for (int i = 0; i < 64; i++) ram[i] = 20'sd524287;
        cfg_sym = 0; cfg_taps_m1 = 7'd63; cfg_scale = 2'd3; cfg_coef_base = 0;
        do_reset();
        for (int k = 0; k < 3; k++) send_sample(524287, "R6 sat hi", 0, 0);
        for (int k = 0; k < 8; k++) send_sample(-524288, "R6 sat lo", 0, 0);
    endtask

    task automatic t_dec();
        ram[0] = 20'sd200000; ram[1] = 20'sd150000; ram[2] = -20'sd90000;
        cfg_sym = 0; cfg_taps_m1 = 7'd2; cfg_scale = 2'd3; cfg_coef_base = 0;
        cfg_dec_m1 = 4'd3; cfg_phase = 4'd2;
        do_reset();
        for (int k = 0; k < 9; k++) send_sample(longint'(k * 50000 - 200000), "R7 dec4", 0, 0);
        cfg_dec_m1 = 4'd1; cfg_phase = 4'd0;
        do_reset();
        for (int k = 0; k < 5; k++) send_sample(longint'(k * 70001 - 100000), "R7 dec2", 0, 0);
        cfg_dec_m1 = 0; cfg_phase = 0;
    endtask

    task automatic t_bypass();
        cfg_bypass = 1; cfg_scale = 2'd0; cfg_dec_m1 = 4'd5;
        do_reset();
        send_sample(-524288, "R9", 0, 0);
        send_sample(12345, "R9", 0, 0);
        send_sample(524287, "R9", 0, 0);
        cfg_bypass = 0; cfg_dec_m1 = 0;
    endtask

    task automatic t_offset();
        for (int i = 0; i < 64; i++) ram[i] = 20'sd0;
        for (int i = 0; i < 8; i++) begin
            ram[i] = 20'(10000 * (i + 1));
            ram[32 + i] = 20'(-25000 * (i + 2));
            ram[(60 + i) % 64] += 20'(3000 * i + 500);
        end
        cfg_sym = 0; cfg_taps_m1 = 7'd7; cfg_scale = 2'd3; cfg_coef_base = 0;
        do_reset();
        send_sample(250000, "R10 old base", 3, 32);
        check(cfg_coef_base == 6'd32, "R10 setup", longint'(cfg_coef_base), 32);
        send_sample(-180000, "R10 new base", 0, 0);
        cfg_coef_base = 6'd60;
        send_sample(90000, "R10 wrap", 0, 0);
    endtask

    initial begin
        t_reset();
        t_plain();
        t_clamp();
        t_sym();
        t_scale();
        t_sat();
        t_dec();
        t_bypass();
        t_offset();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule